// File: doc/BRIEF.md
# DAC Shadow Value Register Controller

This block sits on the register side of a 12-bit buffered digital-to-analog converter. A simple bus port writes a new code into a shadow register. An active register drives the converter code. A mode bit chooses how the code moves from shadow to active: either in the same cycle as the write, or on the next PWM synchronization strobe. Sync-timed loading lets firmware stage a new level at any time and have it take effect on a PWM period boundary.

The controller also holds the reference and gain configuration and raises a flag when the selected reference and gain pair is not a supported one. A module clock enable freezes every register while the current output code stays on the pins. When the enable returns, the block continues from the contents it held before it was frozen.

Control word layout, at address 0: bit 0 `sync_load` (1 = load on strobe, 0 = load on write), bit 1 `gain_x2` (1 = double gain), bit 2 `ref_path` (0 = external converter reference, 1 = high-reference path), bit 3 `hi_ext` (1 = external high-reference pin, 0 = internal generator), bit 4 `lvl_hi` (1 = 2.5 V internal level, 0 = 1.65 V). Address 1 is the shadow value, address 2 is the read-only active value, and address 3 reads as zero.

Top module: `dac_shadow_ctrl`

## Requirements
- R1: After reset the shadow and active values are 0, the control word is 0 (load on write, gain x1, external converter reference), `dac_code` is 0 and `cfg_ok` is 1.
- R2: With `sync_load`=0, a write to address 1 while `clk_en`=1 makes `dac_code` equal to the written code after that clock edge.
- R3: With `sync_load`=1, a shadow write leaves `dac_code` unchanged. On the next `sync_pulse` with `clk_en`=1, the shadow value moves into the active register. A strobe with no new write leaves the code unchanged.
- R4: With `sync_load`=1, when several shadow writes land between two strobes, only the last written value reaches `dac_code`.
- R5: With `sync_load`=1, when a shadow write and `sync_pulse` fall in the same cycle, the value written in that cycle is the one moved to `dac_code`.
- R6: While `clk_en`=0, writes, control changes and strobes have no effect. `dac_code` holds its value. After `clk_en` returns to 1, the shadow, active and control contents are the ones held before the freeze.
- R7: A write to address 2 (active value) is ignored.
- R8: A read with `rd_en`=1 returns, one cycle later on `rdata`, the zero-extended control word (addr 0), shadow (addr 1), active value (addr 2) or 0 (addr 3).
- R9: With `gain_x2`=1, `cfg_ok` is 1 only when `ref_path`=1, `hi_ext`=0 and `lvl_hi`=0. It is 0 for every other combination.
- R10: With `gain_x2`=0, `cfg_ok` is 1 for the external converter reference, the external high-reference pin and the 2.5 V internal level. It is 0 for the 1.65 V internal level.
- R11: When `ref_path`=0, the values of `hi_ext` and `lvl_hi` do not affect `cfg_ok`.
- R12: Only bits [11:0] of a shadow write are kept. Full scale 4095 is reproduced exactly on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Module clock enable; 0 freezes all registers |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| sync_pulse | input | 1 | Single-cycle PWM period strobe |
| dac_code | output | 12 | Active converter code |
| cfg_ok | output | 1 | 1 when the reference/gain pair is supported |

## Verification
Assertions check on every cycle that an immediate-mode write lands in the active register and that a strobe in the same cycle as a write transfers the new value. They also check that the active code is stable between strobes in sync mode, that nothing changes while the clock enable is low, and that the flag agrees with the double-gain and external-reference settings. Only the bench scenarios can show the ordering properties across several transactions: the last-write-wins rule, state retention across a freeze and re-enable, the ignored write to the active address, and the full sweep of all 32 control words against the legality rule.

// File: rtl/dac_shadow_pkg.sv
package dac_shadow_pkg;

  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_SHADOW = 2'd1,
    A_ACTIVE = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;

  // packed MSB first: lvl_hi is bit 4, sync_load is bit 0
  typedef struct packed {
    logic lvl_hi;
    logic hi_ext;
    logic ref_path;
    logic gain_x2;
    logic sync_load;
  } ctrl_t;

  // legality of the reference / gain pair
  function automatic logic combo_ok(ctrl_t c);
    logic int_low;
    int_low = c.ref_path & ~c.hi_ext & ~c.lvl_hi;
    if (!c.ref_path)     return ~c.gain_x2;
    else if (c.hi_ext)   return ~c.gain_x2;
    else if (c.lvl_hi)   return ~c.gain_x2;
    else                 return int_low & c.gain_x2;
  endfunction

endpackage

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_shadow_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_en,
  input  logic                wr_en,
  input  reg_addr_e           addr,
  input  logic [CTRL_W-1:0]   wdata,
  output ctrl_t               ctrl_q,
  output logic                cfg_ok_q
);

  logic  wr_ctrl;
  ctrl_t ctrl_d;

  assign wr_ctrl = wr_en && (addr == A_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (clk_en && wr_ctrl) ctrl_d = ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      cfg_ok_q <= 1'b1;
    end else if (clk_en) begin
      ctrl_q   <= ctrl_d;
      cfg_ok_q <= combo_ok(ctrl_d);
    end
  end

  // R9: double gain on the external converter reference is never legal
  assert_x2_ext_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.gain_x2 && !ctrl_q.ref_path) |-> !cfg_ok_q);

  // R10: unity gain with the external high-reference pin is legal
  assert_x1_hipin_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.gain_x2 && ctrl_q.ref_path && ctrl_q.hi_ext) |-> cfg_ok_q);

  // R6: configuration frozen while the clock enable is low
  assert_cfg_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(ctrl_q) && $stable(cfg_ok_q)));

endmodule

// File: rtl/dac_value_path.sv
module dac_value_path
  import dac_shadow_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              wr_en,
  input  reg_addr_e         addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sync_load,
  input  logic              sync_pulse,
  output logic [DATA_W-1:0] shadow_q,
  output logic [DATA_W-1:0] active_q
);

  logic wr_sh;
  logic load_now;
  logic [DATA_W-1:0] load_val;

  assign wr_sh = wr_en && (addr == A_SHADOW);

  always_comb begin
    load_now = 1'b0;
    load_val = shadow_q;
    if (!sync_load) begin
      load_now = wr_sh;
      load_val = wdata;
    end else if (sync_pulse) begin
      load_now = 1'b1;
      load_val = wr_sh ? wdata : shadow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else if (clk_en) begin
      if (wr_sh)    shadow_q <= wdata;
      if (load_now) active_q <= load_val;
    end
  end

  // R2: immediate mode copies the written code
  assert_imm_load_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && wr_en && addr == A_SHADOW && !sync_load) |=> (active_q == $past(wdata)));

  // R3: in sync mode the active code only moves on a strobe
  assert_hold_sync_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sync_load && !sync_pulse) |=> $stable(active_q));

  // R5: write and strobe together carry the fresh value
  assert_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sync_load && sync_pulse && wr_en && addr == A_SHADOW) |=> (active_q == $past(wdata)));

  // R6: values frozen while the clock enable is low
  assert_val_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(active_q) && $stable(shadow_q)));

endmodule

// File: rtl/dac_rd_port.sv
module dac_rd_port
  import dac_shadow_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_addr_e         addr,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] shadow,
  input  logic [DATA_W-1:0] active,
  output logic [BUS_W-1:0]  rdata_q
);

  localparam int VPAD = BUS_W - DATA_W;
  localparam int CPAD = BUS_W - CTRL_W;

  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    unique case (addr)
      A_CTRL:   rd_mux = {{CPAD{1'b0}}, ctrl};
      A_SHADOW: rd_mux = {{VPAD{1'b0}}, shadow};
      A_ACTIVE: rd_mux = {{VPAD{1'b0}}, active};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  // R8: spare address reads as zero
  assert_spare_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_SPARE) |=> (rdata_q == '0));

endmodule

// File: rtl/dac_shadow_ctrl.sv
module dac_shadow_ctrl
  import dac_shadow_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              sync_pulse,
  output logic [DATA_W-1:0] dac_code,
  output logic              cfg_ok
);

  reg_addr_e         addr_e;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] active_q;

  assign addr_e = reg_addr_e'(addr);

  generate
    if (BUS_W > DATA_W) begin : g_hi
      logic unused_hi_bits;
      assign unused_hi_bits = ^wdata[BUS_W-1:DATA_W];
    end
  endgenerate

  dac_cfg_regs u_cfg (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .wr_en    (wr_en),
    .addr     (addr_e),
    .wdata    (wdata[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .cfg_ok_q (cfg_ok)
  );

  dac_value_path #(.DATA_W(DATA_W)) u_val (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .wr_en      (wr_en),
    .addr       (addr_e),
    .wdata      (wdata[DATA_W-1:0]),
    .sync_load  (ctrl_q.sync_load),
    .sync_pulse (sync_pulse),
    .shadow_q   (shadow_q),
    .active_q   (active_q)
  );

  dac_rd_port #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr_e),
    .ctrl    (ctrl_q),
    .shadow  (shadow_q),
    .active  (active_q),
    .rdata_q (rdata)
  );

  assign dac_code = active_q;

  // R7: a write aimed at the active address changes nothing
  assert_active_ro_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_e == A_ACTIVE && !sync_pulse) |=> $stable(dac_code));

endmodule

// File: tb/tb_dac_shadow_ctrl.sv
module tb_dac_shadow_ctrl;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 12;
  localparam int BUS_W  = 16;

  logic              clk = 1'b0;
  logic              rst, clk_en, wr_en, rd_en, sync_pulse;
  logic [1:0]        addr;
  logic [BUS_W-1:0]  wdata;
  logic [BUS_W-1:0]  rdata;
  logic [DATA_W-1:0] dac_code;
  logic              cfg_ok;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_shadow_ctrl #(.DATA_W(DATA_W), .BUS_W(BUS_W)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sync_pulse(sync_pulse),
    .dac_code(dac_code), .cfg_ok(cfg_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [BUS_W-1:0] d, input logic pulse);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; sync_pulse = pulse;
    @(negedge clk);
    wr_en = 1'b0; sync_pulse = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [BUS_W-1:0] r;
    check("R1 dac_code", dac_code, 0);
    check("R1 cfg_ok", cfg_ok, 1);
    bus_rd(2'd0, r); check("R1 ctrl", r, 0);
    bus_rd(2'd1, r); check("R1 shadow", r, 0);
  endtask

  task automatic t_immediate();
    bus_wr(2'd1, 16'h05A5, 1'b0); check("R2 imm", dac_code, 12'h5A5);
    bus_wr(2'd1, 16'h0FFF, 1'b0); check("R12 full scale", dac_code, 4095);
    bus_wr(2'd1, 16'h1ABC, 1'b0); check("R12 upper bits dropped", dac_code, 12'hABC);
  endtask

  task automatic t_sync();
    bus_wr(2'd0, 16'h0001, 1'b0);
    bus_wr(2'd1, 16'h0321, 1'b0); check("R3 held", dac_code, 12'hABC);
    strobe();                     check("R3 strobe load", dac_code, 12'h321);
    strobe();                     check("R3 idle strobe", dac_code, 12'h321);
  endtask

  task automatic t_last_write();
    bus_wr(2'd1, 16'h0111, 1'b0);
    bus_wr(2'd1, 16'h0222, 1'b0);
    bus_wr(2'd1, 16'h0333, 1'b0); check("R4 before strobe", dac_code, 12'h321);
    strobe();                     check("R4 last wins", dac_code, 12'h333);
  endtask

  task automatic t_same_cycle();
    bus_wr(2'd1, 16'h0777, 1'b1); check("R5 same cycle", dac_code, 12'h777);
  endtask

  task automatic t_readonly();
    logic [BUS_W-1:0] r;
    bus_wr(2'd2, 16'h00F0, 1'b0); check("R7 code kept", dac_code, 12'h777);
    bus_rd(2'd2, r); check("R7 R8 active read", r, 16'h0777);
    bus_rd(2'd1, r); check("R8 shadow read", r, 16'h0777);
    bus_rd(2'd3, r); check("R8 spare read", r, 0);
  endtask

  task automatic t_freeze();
    logic [BUS_W-1:0] r;
    @(negedge clk); clk_en = 1'b0;
    bus_wr(2'd1, 16'h0456, 1'b0);
    bus_wr(2'd0, 16'h0000, 1'b0);
    strobe();
    bus_wr(2'd1, 16'h0999, 1'b1);
    check("R6 code held", dac_code, 12'h777);
    @(negedge clk); clk_en = 1'b1;
    bus_rd(2'd1, r); check("R6 shadow kept", r, 16'h0777);
    bus_rd(2'd0, r); check("R6 ctrl kept", r, 16'h0001);
    bus_wr(2'd1, 16'h0456, 1'b0); check("R6 R3 resume held", dac_code, 12'h777);
    strobe();                     check("R6 R3 resume load", dac_code, 12'h456);
  endtask

  task automatic t_legality();
    for (int c = 0; c < 32; c++) begin
      logic g, rp, he, lv, exp_ok;
      g = c[1]; rp = c[2]; he = c[3]; lv = c[4];
      exp_ok = (g == (rp & ~he & ~lv));
      bus_wr(2'd0, 16'(c), 1'b0);
      if (!rp)     check("R11 R9 R10 ext ref", cfg_ok, exp_ok);
      else if (g)  check("R9 x2 combo", cfg_ok, exp_ok);
      else         check("R10 x1 combo", cfg_ok, exp_ok);
    end
    bus_wr(2'd0, 16'h0000, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; clk_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    sync_pulse = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_immediate();
    t_sync();
    t_last_write();
    t_same_cycle();
    t_readonly();
    t_freeze();
    t_legality();
    summary();
    $finish;
  end

endmodule